// File: doc/BRIEF.md
# RAID-6 Dual Parity Generator

This block computes both parity vectors of a RAID-6 stripe in one pass over the data. The first is P, the bytewise XOR of all data blocks. The second is Q, a Reed-Solomon syndrome over GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1, whose low byte is 0x1D. An upstream engine streams the stripe one beat per data disk. Each beat is a wide vector of independent byte lanes, 64 by default. The beats run from the highest data disk down to disk 0.

With N disks in the array, the data disks are numbered 0 to N-3, and N-2 and N-1 are the disks that hold P and Q. The count N is presented with the first beat of a stripe and is sampled only then. The first beat, from disk N-3, loads both accumulators directly. Each later beat from disk z updates them in two ways. Every lane of Q is first doubled in the field, then XORed with D[z]. P is XORed with D[z]. After the beat for disk 0 is taken, the finished P and Q appear on registered outputs for one cycle, and the accumulators return to zero ready for the next stripe.

Top module: `pq_syndrome_gen`

## Requirements
- R1: While reset is held and right after it, out_valid is 0, in_ready is 1 and both result vectors read zero.
- R2: out_p equals the XOR of the N-2 data beats of the stripe, computed in every byte lane.
- R3: In every lane, out_q equals the Horner recurrence over the data bytes from disk N-3 down to disk 0. The recurrence starts from the byte of disk N-3, then repeats q = dbl(q) XOR d. Here dbl(b) is b shifted left by one bit and, when bit 7 of b was 1, XORed with 0x1D.
- R4: A stripe consists of exactly N-2 accepted beats. N is taken from in_disks on the first beat only (N is at least 4), and in_disks on every later beat is ignored.
- R5: out_valid is high for exactly one cycle, the cycle after the beat of disk 0 is accepted, and is low for every earlier beat of the stripe.
- R6: in_ready is low during the cycle in which out_valid is high, and high in every other cycle after reset.
- R7: Byte lanes do not interact. A non-zero byte in one lane leaves every other lane of P and Q at zero.
- R8: Each stripe starts from fresh accumulators, so a result never depends on data from an earlier stripe.
- R9: A cycle in which in_valid is low changes neither accumulator, whatever in_data carries.
- R10: out_p and out_q hold their value from one result until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data beat is offered |
| in_ready | output | 1 | The block can take a beat this cycle |
| in_data | input | LANES*8 | One data block, byte lane k in bits 8k+7:8k |
| in_disks | input | DISK_W | Total disk count N, read on the first beat of a stripe |
| out_valid | output | 1 | One-cycle strobe marking a finished stripe |
| out_p | output | LANES*8 | XOR parity of the last finished stripe |
| out_q | output | LANES*8 | GF(2^8) syndrome of the last finished stripe |

## Verification
The checks assume that in_disks is at least 4 whenever the beat starting a stripe is accepted. They also assume that no stripe is left unfinished when a new count is expected. The beat count check relies on the same assumption, and the bench keeps within it by sweeping N only from 4 upward. The bench always sends full stripes of N-2 beats. On every later beat it drives random junk on in_disks, and it also puts random data on in_data during idle gaps. This shows that neither of those inputs can reach the result.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GF_POLY = 8'h1D;

  // GF(2^8) multiply by the generator element 2.
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? GF_POLY : '0);
  endfunction
endpackage

// File: rtl/pq_lane.sv
// One byte lane of the dual-parity datapath: next P and Q values.
module pq_lane
  import pq_pkg::*;
(
  input  logic              first,
  input  logic [BYTE_W-1:0] d,
  input  logic [BYTE_W-1:0] p_acc,
  input  logic [BYTE_W-1:0] q_acc,
  output logic [BYTE_W-1:0] p_nxt,
  output logic [BYTE_W-1:0] q_nxt
);
  always_comb begin
    if (first) begin
      p_nxt = d;
      q_nxt = d;
    end else begin
      p_nxt = p_acc ^ d;
      q_nxt = gf_dbl(q_acc) ^ d;
    end
  end
endmodule

// File: rtl/pq_disk_seq.sv
// Tracks the disk index of the next expected beat in a stripe.
module pq_disk_seq #(
  parameter int unsigned DISK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DISK_W-1:0] disks,
  output logic              first,
  output logic              last
);
  logic              active_q, active_d;
  logic [DISK_W-1:0] idx_q, idx_d;

  assign first = !active_q;
  assign last  = active_q && (idx_q == '0);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (accept) begin
      if (first) begin
        active_d = 1'b1;
        idx_d    = disks - DISK_W'(4);
      end else if (last) begin
        active_d = 1'b0;
      end else begin
        idx_d = idx_q - DISK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (accept) begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen
  import pq_pkg::*;
#(
  parameter int unsigned LANES  = 64,
  parameter int unsigned DISK_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*BYTE_W-1:0]   in_data,
  input  logic [DISK_W-1:0]         in_disks,
  output logic                      out_valid,
  output logic [LANES*BYTE_W-1:0]   out_p,
  output logic [LANES*BYTE_W-1:0]   out_q
);
  localparam int unsigned VEC_W = LANES * BYTE_W;

  logic             accept, first, last;
  logic [VEC_W-1:0] p_acc_q, q_acc_q, p_acc_d, q_acc_d;
  logic [VEC_W-1:0] p_nxt, q_nxt;
  logic [VEC_W-1:0] out_p_q, out_q_q;
  logic             out_valid_q, out_valid_d;

  assign in_ready = !out_valid_q;
  assign accept   = in_valid && in_ready;

  pq_disk_seq #(.DISK_W(DISK_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .disks  (in_disks),
    .first  (first),
    .last   (last)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pq_lane u_lane (
      .first (first),
      .d     (in_data[k*BYTE_W +: BYTE_W]),
      .p_acc (p_acc_q[k*BYTE_W +: BYTE_W]),
      .q_acc (q_acc_q[k*BYTE_W +: BYTE_W]),
      .p_nxt (p_nxt[k*BYTE_W +: BYTE_W]),
      .q_nxt (q_nxt[k*BYTE_W +: BYTE_W])
    );
  end

  // Next-state: accumulators clear on the closing beat.
  always_comb begin
    p_acc_d     = p_acc_q;
    q_acc_d     = q_acc_q;
    out_valid_d = 1'b0;
    if (accept) begin
      if (last) begin
        p_acc_d     = '0;
        q_acc_d     = '0;
        out_valid_d = 1'b1;
      end else begin
        p_acc_d = p_nxt;
        q_acc_d = q_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_acc_q <= '0;
      q_acc_q <= '0;
    end else if (accept) begin
      p_acc_q <= p_acc_d;
      q_acc_q <= q_acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_p_q <= '0;
      out_q_q <= '0;
    end else if (accept && last) begin
      out_p_q <= p_nxt;
      out_q_q <= q_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= out_valid_d;
  end

  assign out_valid = out_valid_q;
  assign out_p     = out_p_q;
  assign out_q     = out_q_q;
endmodule

// File: rtl/pq_syndrome_chk.sv
module pq_syndrome_chk #(
  parameter int unsigned LANES  = 64,
  parameter int unsigned DISK_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [DISK_W-1:0]      in_disks,
  input logic                   out_valid,
  input logic [LANES*8-1:0]     out_p,
  input logic [LANES*8-1:0]     out_q
);
  logic [DISK_W-1:0] beats_seen, n_saved;
  logic              acc;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_seen <= '0;
      n_saved    <= '0;
    end else if (out_valid) begin
      beats_seen <= '0;
    end else if (acc) begin
      beats_seen <= beats_seen + DISK_W'(1);
      if (beats_seen == '0) n_saved <= in_disks;
    end
  end

  // Input assumption behind R4: a stripe needs at least 4 disks.
  p_min_disks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && beats_seen == '0) |-> (in_disks >= DISK_W'(4)));

  p_beat_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (beats_seen == n_saved - DISK_W'(2)));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_valid_after_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));

  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_p) && $stable(out_q)));
endmodule

bind pq_syndrome_gen pq_syndrome_chk #(.LANES(LANES), .DISK_W(DISK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_disks  (in_disks),
  .out_valid (out_valid),
  .out_p     (out_p),
  .out_q     (out_q)
);

// File: tb/pq_syndrome_gen_tb.sv
module pq_syndrome_gen_tb;
  localparam int LANES  = 64;
  localparam int DISK_W = 8;
  localparam int W      = LANES * 8;

  logic             clk, rst_n;
  logic             in_valid, in_ready, out_valid;
  logic [W-1:0]     in_data, out_p, out_q;
  logic [DISK_W-1:0] in_disks;

  int n_chk = 0;
  int n_bad = 0;

  pq_syndrome_gen #(.LANES(LANES), .DISK_W(DISK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_disks(in_disks), .out_valid(out_valid),
    .out_p(out_p), .out_q(out_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbl(input logic [7:0] b);
    logic [8:0] s;
    s = {b, 1'b0};
    return s[8] ? (s[7:0] ^ 8'h1D) : s[7:0];
  endfunction

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  logic [W-1:0] dat [0:31];

  task automatic run_stripe(input int n, input int mode, input bit gaps);
    logic [W-1:0] ep, eq, held_p;
    logic [7:0]   qb;
    for (int z = 0; z <= n - 3; z++) begin
      case (mode)
        0: dat[z] = rnd_vec();
        1: dat[z] = '1;
        2: dat[z] = (z == n - 3) ? (W'(8'h80) << (8 * (n % LANES))) : '0;
        default: dat[z] = (z == 0) ? rnd_vec() : '0;
      endcase
    end
    // byte-serial reference: P by XOR, Q by Horner from disk n-3 down
    ep = '0;
    for (int k = 0; k < LANES; k++) begin
      qb = dat[n-3][k*8 +: 8];
      for (int z = n - 4; z >= 0; z--) qb = dbl(qb) ^ dat[z][k*8 +: 8];
      eq[k*8 +: 8] = qb;
    end
    for (int z = 0; z <= n - 3; z++) ep = ep ^ dat[z];

    for (int z = n - 3; z >= 0; z--) begin
      if (gaps && (z % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;               // R9: junk on an idle cycle
        in_data  = rnd_vec();
        in_disks = DISK_W'($urandom);
      end
      @(negedge clk);
      if (z != n - 3)
        chk(out_valid == 1'b0, "R5 early strobe", W'(out_valid), '0);
      in_valid = 1'b1;
      in_data  = dat[z];
      in_disks = (z == n - 3) ? DISK_W'(n) : DISK_W'($urandom); // R4
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = rnd_vec();
    chk(out_valid == 1'b1, "R5 strobe", W'(out_valid), W'(1));
    chk(in_ready == 1'b0, "R6 ready low", W'(in_ready), '0);
    chk(out_p == ep, "R2 P", out_p, ep);
    chk(out_q == eq, "R3 Q", out_q, eq);
    if (mode == 2) begin
      // R7: only lane n%64 carries data
      chk((out_p & ~(W'(8'hFF) << (8 * (n % LANES)))) == '0, "R7 lane isolation",
          out_p, ep);
    end
    held_p = out_p;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 one-cycle strobe", W'(out_valid), '0);
    chk(in_ready == 1'b1, "R6 ready back", W'(in_ready), W'(1));
    repeat (2) @(negedge clk);
    chk(out_p == held_p, "R10 hold", out_p, held_p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_disks = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset flags",
        W'({out_valid, in_ready}), W'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_p == '0 && out_q == '0 && out_valid == 1'b0, "R1 after reset",
        out_p | out_q, '0);
    // sweep disk counts and patterns; back-to-back stripes exercise R8
    for (int n = 4; n <= 19; n++)
      for (int m = 0; m < 4; m++)
        run_stripe(n, m, (n + m) % 2 == 1);
    run_stripe(32, 0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule